// File: doc/BRIEF.md
# Fractional Time-of-Day Counter with One-Shot Time Adjust

This block keeps wall-clock time in a nanosecond field, a 32-bit fraction of a nanosecond, and a 32-bit seconds count, all running on the local reference clock. Each cycle in which counting is enabled, a 64-bit compensation step is added to the combined nanosecond/fraction value. The step is in 32.32 fixed point: the upper half is whole nanoseconds and the lower half is the fraction. Its nominal value is (10^9 · 2^32) / f_clk, with f_clk in Hz. When the nanosecond field reaches one billion, only the excess is kept, so no time is lost, and the seconds count steps up.

Software programs the block through a simple write port. Through it, software loads the step, a configuration word, and a set of staged values: nanoseconds, fraction, seconds, and two 64-bit boundary marks. A one-shot opcode in the configuration word applies an adjustment in a single cycle. The adjustment either loads the whole staged time, or adds or subtracts the staged nanosecond offset to or from live time, with the carry or borrow passed into the seconds count. The live time, the boundary marks and the configuration word are always visible on output ports.

Top module: `tod_counter`

## Requirements
- R1: While config bit 0 is set, every clock edge adds the 64-bit step to {nanoseconds, fraction}, with a fraction carry going into nanoseconds.
- R2: When nanoseconds would reach 1,000,000,000 or more, the field takes the value minus 1,000,000,000 and seconds increase by one (modulo 2^32).
- R3: While config bit 0 is clear and no opcode is pending, nanoseconds, fraction and seconds hold.
- R4: Write addresses are as follows. 0 is the step (64 bits). 1 is the config word (low 32 bits). 2 is staged nanoseconds, 3 is staged fraction and 4 is staged seconds. 5 is the current boundary and 6 is the next boundary (64 bits each). Address 7 is ignored. A write takes effect at the edge where wrEn is sampled high.
- R5: Opcode 1 in config bits 28:26 (SET) loads nanoseconds, fraction, seconds and both boundaries from the staged values. The load happens at the edge after the config write, and it happens whether or not counting is enabled.
- R6: Opcode 3 (INCREMENT) adds the staged nanoseconds (less than 10^9) to live time, on top of that edge's step. Any carry goes into seconds.
- R7: Opcode 4 (DECREMENT) subtracts the staged nanoseconds. On a borrow, nanoseconds wrap up by 10^9 and seconds decrease by one.
- R8: The opcode field reads zero from the edge at which it is applied, and every other config bit keeps its value. Opcodes 0, 2, 5, 6 and 7 do not change the time, but they are cleared in the same way.
- R9: When seconds step up, the current boundary takes the next boundary and the next boundary increases by 10^9. When a decrement borrows, the next boundary takes the current boundary and the current boundary decreases by 10^9.
- R10: After reset, time, step and config are zero, the current boundary is 0, and the next boundary is 1,000,000,000.
- R11: Nanoseconds stay below 1,000,000,000, provided the staged nanoseconds and the step's whole part are below 10^9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 64 | Write data |
| nsOut | output | 32 | Live nanoseconds |
| fracOut | output | 32 | Live fraction of a nanosecond |
| secOut | output | 32 | Live seconds |
| curBound | output | 64 | Current one-second boundary mark |
| nxtBound | output | 64 | Next one-second boundary mark |
| cfgOut | output | 32 | Configuration word |

## Verification
A wrong fraction carry or a skipped step shows up on nsOut at the very next edge, because the bench model predicts every cycle's value. A bad wrap value or a missed seconds carry shows on nsOut and secOut, and on both boundary marks, in the cycle the wrap occurs. An opcode that fails to clear changes time again one edge later, and cfgOut exposes the stuck field in the same cycle. Errors in staged registers stay hidden until a SET, INCREMENT or DECREMENT reads them, so the bench performs each operation after staging.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int OP_LSB = 26;
  localparam int OP_W   = 3;
  localparam int EN_BIT = 0;

  localparam logic [OP_W-1:0] OP_NONE = 3'd0;
  localparam logic [OP_W-1:0] OP_SET  = 3'd1;
  localparam logic [OP_W-1:0] OP_INC  = 3'd3;
  localparam logic [OP_W-1:0] OP_DEC  = 3'd4;

  localparam int ADDR_COMP = 0;
  localparam int ADDR_CFG  = 1;
  localparam int ADDR_NS   = 2;
  localparam int ADDR_FRAC = 3;
  localparam int ADDR_SEC  = 4;
  localparam int ADDR_CUR  = 5;
  localparam int ADDR_NXT  = 6;

  typedef struct packed {
    logic ldComp;
    logic ldNs;
    logic ldFrac;
    logic ldSec;
    logic ldCur;
    logic ldNxt;
    logic run;
    logic opSet;
    logic opInc;
    logic opDec;
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrCfg,
  output todStrobe_t        strb,
  output logic [CFG_W-1:0]  cfgOut
);
  logic [CFG_W-1:0] cfgQ;
  logic [OP_W-1:0]  opField;
  logic             cfgHit;

  assign opField = cfgQ[OP_LSB +: OP_W];
  assign cfgHit  = wrEn && (wrAddr == ADDR_W'(ADDR_CFG));

  // config register: a write wins, otherwise a pending opcode clears itself
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgHit) begin
      cfgQ <= wrCfg;
    end else if (opField != OP_NONE) begin
      cfgQ[OP_LSB +: OP_W] <= OP_NONE;
    end
  end

  always_comb begin
    strb        = '0;
    strb.run    = cfgQ[EN_BIT];
    strb.opSet  = (opField == OP_SET);
    strb.opInc  = (opField == OP_INC);
    strb.opDec  = (opField == OP_DEC);
    if (wrEn) begin
      case (int'(wrAddr))
        ADDR_COMP: strb.ldComp = 1'b1;
        ADDR_NS:   strb.ldNs   = 1'b1;
        ADDR_FRAC: strb.ldFrac = 1'b1;
        ADDR_SEC:  strb.ldSec  = 1'b1;
        ADDR_CUR:  strb.ldCur  = 1'b1;
        ADDR_NXT:  strb.ldNxt  = 1'b1;
        default:   ;
      endcase
    end
  end

  assign cfgOut = cfgQ;
endmodule

// File: rtl/tod_norm.sv
module tod_norm #(
  parameter int NS_W       = 32,
  parameter int NS_PER_SEC = 1000000000,
  localparam int RAW_W     = NS_W + 3
) (
  input  logic signed [RAW_W-1:0] nsRaw,
  output logic [NS_W-1:0]         nsFix,
  output logic                    secUp,
  output logic                    secDown
);
  localparam logic signed [RAW_W-1:0] LIM = RAW_W'(NS_PER_SEC);
  logic signed [RAW_W-1:0] adj;

  always_comb begin
    secUp   = (nsRaw >= LIM);
    secDown = (nsRaw < 0);
    if (secUp)        adj = nsRaw - LIM;
    else if (secDown) adj = nsRaw + LIM;
    else              adj = nsRaw;
    nsFix = adj[NS_W-1:0];
  end
endmodule

// File: rtl/tod_dpath.sv
module tod_dpath
  import tod_pkg::*;
#(
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 32,
  parameter int BOUND_W    = 64,
  parameter int DATA_W     = 64,
  parameter int NS_PER_SEC = 1000000000,
  localparam int COMP_W    = NS_W + FRAC_W,
  localparam int RAW_W     = NS_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  todStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [NS_W-1:0]    nsOut,
  output logic [FRAC_W-1:0]  fracOut,
  output logic [SEC_W-1:0]   secOut,
  output logic [BOUND_W-1:0] curBound,
  output logic [BOUND_W-1:0] nxtBound
);
  localparam logic [BOUND_W-1:0] SEC_SPAN = BOUND_W'(NS_PER_SEC);

  logic [COMP_W-1:0]  compQ;
  logic [NS_W-1:0]    stNs, nsQ;
  logic [FRAC_W-1:0]  stFrac, fracQ;
  logic [SEC_W-1:0]   stSec, secQ;
  logic [BOUND_W-1:0] stCur, stNxt, curQ, nxtQ;

  logic [COMP_W-1:0]      addVal;
  logic [FRAC_W:0]        fracSum;
  logic [NS_W:0]          nsBase;
  logic signed [RAW_W-1:0] offs, nsRaw;
  logic [NS_W-1:0]        nsFix;
  logic                   secUp, secDown;

  // staging and step registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      compQ  <= '0;
      stNs   <= '0;
      stFrac <= '0;
      stSec  <= '0;
      stCur  <= '0;
      stNxt  <= '0;
    end else begin
      if (strb.ldComp) compQ  <= wrData[COMP_W-1:0];
      if (strb.ldNs)   stNs   <= wrData[NS_W-1:0];
      if (strb.ldFrac) stFrac <= wrData[FRAC_W-1:0];
      if (strb.ldSec)  stSec  <= wrData[SEC_W-1:0];
      if (strb.ldCur)  stCur  <= wrData[BOUND_W-1:0];
      if (strb.ldNxt)  stNxt  <= wrData[BOUND_W-1:0];
    end
  end

  // per-cycle sum with optional offset on top
  always_comb begin
    addVal  = strb.run ? compQ : '0;
    fracSum = {1'b0, fracQ} + {1'b0, addVal[FRAC_W-1:0]};
    nsBase  = {1'b0, nsQ} + {1'b0, addVal[COMP_W-1:FRAC_W]}
            + {{NS_W{1'b0}}, fracSum[FRAC_W]};
    if (strb.opInc)      offs = $signed({3'b000, stNs});
    else if (strb.opDec) offs = -$signed({3'b000, stNs});
    else                 offs = '0;
    nsRaw = $signed({2'b00, nsBase}) + offs;
  end

  tod_norm #(
    .NS_W       (NS_W),
    .NS_PER_SEC (NS_PER_SEC)
  ) u_norm (
    .nsRaw   (nsRaw),
    .nsFix   (nsFix),
    .secUp   (secUp),
    .secDown (secDown)
  );

  // live time and boundary marks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsQ   <= '0;
      fracQ <= '0;
      secQ  <= '0;
      curQ  <= '0;
      nxtQ  <= SEC_SPAN;
    end else if (strb.opSet) begin
      nsQ   <= stNs;
      fracQ <= stFrac;
      secQ  <= stSec;
      curQ  <= stCur;
      nxtQ  <= stNxt;
    end else begin
      nsQ   <= nsFix;
      fracQ <= fracSum[FRAC_W-1:0];
      if (secUp) begin
        secQ <= secQ + SEC_W'(1);
        curQ <= nxtQ;
        nxtQ <= nxtQ + SEC_SPAN;
      end else if (secDown) begin
        secQ <= secQ - SEC_W'(1);
        nxtQ <= curQ;
        curQ <= curQ - SEC_SPAN;
      end
    end
  end

  assign nsOut    = nsQ;
  assign fracOut  = fracQ;
  assign secOut   = secQ;
  assign curBound = curQ;
  assign nxtBound = nxtQ;
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 32,
  parameter int BOUND_W    = 64,
  parameter int ADDR_W     = 3,
  parameter int CFG_W      = 32,
  parameter int NS_PER_SEC = 1000000000,
  localparam int DATA_W    = BOUND_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [NS_W-1:0]    nsOut,
  output logic [FRAC_W-1:0]  fracOut,
  output logic [SEC_W-1:0]   secOut,
  output logic [BOUND_W-1:0] curBound,
  output logic [BOUND_W-1:0] nxtBound,
  output logic [CFG_W-1:0]   cfgOut
);
  todStrobe_t strb;

  tod_ctrl #(
    .ADDR_W (ADDR_W),
    .CFG_W  (CFG_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrCfg  (wrData[CFG_W-1:0]),
    .strb   (strb),
    .cfgOut (cfgOut)
  );

  tod_dpath #(
    .NS_W       (NS_W),
    .FRAC_W     (FRAC_W),
    .SEC_W      (SEC_W),
    .BOUND_W    (BOUND_W),
    .DATA_W     (DATA_W),
    .NS_PER_SEC (NS_PER_SEC)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .nsOut    (nsOut),
    .fracOut  (fracOut),
    .secOut   (secOut),
    .curBound (curBound),
    .nxtBound (nxtBound)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 32,
  parameter int BOUND_W    = 64,
  parameter int ADDR_W     = 3,
  parameter int CFG_W      = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [NS_W-1:0]    nsOut,
  input logic [FRAC_W-1:0]  fracOut,
  input logic [SEC_W-1:0]   secOut,
  input logic [BOUND_W-1:0] curBound,
  input logic [BOUND_W-1:0] nxtBound,
  input logic [CFG_W-1:0]   cfgOut
);
  logic [2:0] opNow;
  logic       cfgWrite;
  assign opNow    = cfgOut[28:26];
  assign cfgWrite = wrEn && (wrAddr == ADDR_W'(1));

  AST_NS_BELOW_SEC: assert property (@(posedge clk) disable iff (!rstN)
    nsOut < NS_W'(NS_PER_SEC)); // R11

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOut[0] && opNow == 3'd0) |=>
      ($stable(nsOut) && $stable(fracOut) && $stable(secOut))); // R3

  AST_OP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (opNow != 3'd0 && !cfgWrite) |=> (opNow == 3'd0)); // R8

  AST_SEC_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOut[0] && opNow == 3'd0) |=>
      (secOut == $past(secOut) || secOut == $past(secOut) + SEC_W'(1))); // R2

  AST_BOUND_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opNow) == 3'd0 && secOut == $past(secOut) + SEC_W'(1)) |->
      (curBound == $past(nxtBound))); // R9
endmodule

bind tod_counter tod_counter_chk #(
  .NS_W       (NS_W),
  .FRAC_W     (FRAC_W),
  .SEC_W      (SEC_W),
  .BOUND_W    (BOUND_W),
  .ADDR_W     (ADDR_W),
  .CFG_W      (CFG_W),
  .NS_PER_SEC (NS_PER_SEC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .nsOut    (nsOut),
  .fracOut  (fracOut),
  .secOut   (secOut),
  .curBound (curBound),
  .nxtBound (nxtBound),
  .cfgOut   (cfgOut)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [31:0] nsOut, fracOut, secOut, cfgOut;
  logic [63:0] curBound, nxtBound;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam longint SEC = 1000000000;
  localparam longint M32 = 64'hFFFF_FFFF;

  always #10 clk = ~clk;

  tod_counter i_tod_counter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .nsOut(nsOut), .fracOut(fracOut), .secOut(secOut),
    .curBound(curBound), .nxtBound(nxtBound), .cfgOut(cfgOut)
  );

  // behavioural reference
  longint mNs, mFrac, mSec, mCur, mNxt, mComp, mCfg;
  longint sNs, sFrac, sSec, sCur, sNxt;

  always @(posedge clk) begin
    if (!rstN) begin
      mNs = 0; mFrac = 0; mSec = 0; mCur = 0; mNxt = SEC; mComp = 0; mCfg = 0;
      sNs = 0; sFrac = 0; sSec = 0; sCur = 0; sNxt = 0;
    end else begin
      longint op, fr, nsv;
      bit run;
      op  = (mCfg >> 26) & 7;
      run = mCfg[0];
      if (op == 1) begin
        mNs = sNs; mFrac = sFrac; mSec = sSec; mCur = sCur; mNxt = sNxt;
      end else begin
        fr  = mFrac + (run ? (mComp & M32) : 0);
        nsv = mNs + (run ? ((mComp >> 32) & M32) : 0) + (fr >> 32);
        mFrac = fr & M32;
        if (op == 3) nsv = nsv + sNs;
        else if (op == 4) nsv = nsv - sNs;
        if (nsv >= SEC) begin
          nsv = nsv - SEC; mSec = (mSec + 1) & M32; mCur = mNxt; mNxt = mNxt + SEC;
        end else if (nsv < 0) begin
          nsv = nsv + SEC; mSec = (mSec - 1) & M32; mNxt = mCur; mCur = mCur - SEC;
        end
        mNs = nsv;
      end
      if (op != 0) mCfg = mCfg & ~(longint'(7) << 26);
      if (wrEn) begin
        case (wrAddr)
          3'd0: mComp = wrData;
          3'd1: mCfg  = wrData & M32;
          3'd2: sNs   = wrData & M32;
          3'd3: sFrac = wrData & M32;
          3'd4: sSec  = wrData & M32;
          3'd5: sCur  = wrData;
          3'd6: sNxt  = wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1 model ns",   {32'd0, nsOut},   mNs);
      chk("R1 model frac", {32'd0, fracOut}, mFrac);
      chk("R2 model sec",  {32'd0, secOut},  mSec);
      chk("R9 model cur",  curBound,         mCur);
      chk("R9 model nxt",  nxtBound,         mNxt);
      chk("R8 model cfg",  {32'd0, cfgOut},  mCfg);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishUp;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  localparam logic [63:0] OPSET = 64'(1) << 26;
  localparam logic [63:0] OPINC = 64'(3) << 26;
  localparam logic [63:0] OPDEC = 64'(4) << 26;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R10 reset state
    chk("R10 ns", {32'd0, nsOut}, 0);
    chk("R10 sec", {32'd0, secOut}, 0);
    chk("R10 cur", curBound, 0);
    chk("R10 nxt", nxtBound, 64'd1000000000);
    chk("R10 cfg", {32'd0, cfgOut}, 0);

    // R4/R5: stage and SET near a boundary, 20 ns step
    wr(3'd0, 64'd20 << 32);
    wr(3'd2, 64'd999999950);
    wr(3'd4, 64'd5);
    wr(3'd5, 64'd5000000000);
    wr(3'd6, 64'd6000000000);
    wr(3'd1, 64'd1 | OPSET);
    tick(1);
    chk("R5 set ns", {32'd0, nsOut}, 999999950);
    chk("R5 set sec", {32'd0, secOut}, 5);
    chk("R5 set cur", curBound, 64'd5000000000);
    chk("R8 op cleared", {32'd0, cfgOut}, 1);
    tick(3);
    // R2 wrap keeps the excess
    chk("R2 wrap ns", {32'd0, nsOut}, 10);
    chk("R2 wrap sec", {32'd0, secOut}, 6);
    chk("R9 cur took nxt", curBound, 64'd6000000000);
    chk("R9 nxt advanced", nxtBound, 64'd7000000000);

    // R3 hold when disabled
    wr(3'd1, 64'd0);
    wr(3'd2, 64'd50);
    tick(2);
    chk("R3 hold ns", {32'd0, nsOut}, 30);
    chk("R3 hold sec", {32'd0, secOut}, 6);

    // R7 decrement with borrow
    wr(3'd1, OPDEC);
    tick(1);
    chk("R7 dec ns", {32'd0, nsOut}, 999999980);
    chk("R7 dec sec", {32'd0, secOut}, 5);
    chk("R9 dec cur", curBound, 64'd5000000000);
    chk("R9 dec nxt", nxtBound, 64'd6000000000);

    // R6 increment with carry
    wr(3'd2, 64'd40);
    wr(3'd1, OPINC);
    tick(1);
    chk("R6 inc ns", {32'd0, nsOut}, 20);
    chk("R6 inc sec", {32'd0, secOut}, 6);

    // R8 unknown opcode: no effect, cleared
    wr(3'd1, 64'(2) << 26);
    tick(1);
    chk("R8 unknown ns", {32'd0, nsOut}, 20);
    chk("R8 unknown cfg", {32'd0, cfgOut}, 0);

    // R4 address 7 ignored
    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    tick(1);
    chk("R4 addr7 ns", {32'd0, nsOut}, 20);
    chk("R4 addr7 cfg", {32'd0, cfgOut}, 0);

    // R1 fractional step 1.5 ns
    wr(3'd0, 64'h0000_0001_8000_0000);
    wr(3'd2, 64'd0);
    wr(3'd3, 64'd0);
    wr(3'd4, 64'd0);
    wr(3'd1, 64'd1 | OPSET);
    tick(1);
    tick(2);
    chk("R1 frac ns", {32'd0, nsOut}, 3);
    chk("R1 frac frac", {32'd0, fracOut}, 0);

    // R6 increment together with the running step
    wr(3'd2, 64'd100);
    wr(3'd1, 64'd1 | OPINC);
    tick(1);
    chk("R6 inc+step ns", {32'd0, nsOut}, 107);
    chk("R6 inc+step frac", {32'd0, fracOut}, 32'h8000_0000);

    // R11 long run with 20 ns step near the wrap; model compares every cycle
    wr(3'd0, 64'd20 << 32);
    wr(3'd2, 64'd999990000);
    wr(3'd1, 64'd1 | OPSET);
    tick(1200);
    chk("R11 ns range", {63'd0, nsOut < 32'd1000000000}, 1);

    finishUp();
  end
endmodule